// File: doc/BRIEF.md
# Serial Two's-Complement Systolic Multiplier

This block multiplies two signed N-bit operands that arrive one bit per clock on two serial wires, least significant bit first. It is a linear chain of N cells. Cells 1 to N-1 each keep one digit of Y and add the bit product of that digit and the passing X bit to a running partial sum. The last cell keeps the sign digit of Y and subtracts its weighted term. The partial sum shifts one place to the right at every cell, so the chain puts out the upper N bits of the 2N-bit product, serially and least significant bit first.

A start pulse marks the cycle that carries bit 0 of both operands. A small controller then frames the operation. It makes the operation one cycle longer than the operand and repeats the X sign bit in that extra cycle. It also drives a control bit that travels with X at two registers per cell, while Y travels at one register per cell. When that bit is low, a cell takes a new Y digit from the passing stream, clears its carry and repeats its last partial-sum bit, which sign-extends the sum it hands on. The last cycle of one operation can therefore be followed at once by the first cycle of the next. The datapath is a fixed systolic pipeline and cannot stall. The inputs have no ready signal, the output has no back-pressure, and `out_valid` flags each result bit as it leaves.

Top module: `serial_tc_mult`

## Requirements
- R1: A `start` that is high while no operation is in progress begins an operation. That cycle carries bit 0 of `x_bit` and `y_bit`, and bit j arrives j cycles later. Each operation lasts N+1 cycles. A new `start` is accepted in the cycle right after the last one.
- R2: For each accepted `start` in cycle c, `out_valid` is high in cycles c+2N through c+3N-1. In cycle c+2N+j, `out_bit` carries bit N+j of the product.
- R3: The N result bits equal bits 2N-1 down to N of the signed 2N-bit product of X and Y, for all operand values, including the most negative value on either or both operands.
- R4: Operations started back to back give independent, correct results. Their result windows are separated by exactly one cycle with `out_valid` low.
- R5: A `start` in cycles 1 to N of an operation is ignored. It neither restarts nor shifts the operation or its result.
- R6: In cycle N of an operation, the values on `x_bit` and `y_bit` are ignored. The block repeats the X sign bit itself.
- R7: `out_valid` is low during and after reset until a result bit arrives. It is high for exactly N consecutive cycles per accepted operation.
- R8: Values on `x_bit` and `y_bit` in idle cycles between operations have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Marks the cycle carrying bit 0 of both operands |
| x_bit | input | 1 | Serial multiplicand, LSB first |
| y_bit | input | 1 | Serial multiplier, LSB first |
| out_bit | output | 1 | Serial upper half of the product, LSB first |
| out_valid | output | 1 | High while `out_bit` carries a result bit |

## Verification
The busiest cycle is the one in which every cell finishes one operation and begins the next. In that cycle the control bit is low, so the cell loads a fresh Y digit and clears its carry while repeating the previous sum's top bit downstream. Back-to-back runs of random operands, some with the most negative value, make this overlap happen at every cell. Each result is then compared with a signed reference product and checked for the exact cycle of its first bit. Starts issued in the middle of a frame and random bits on the ignored sign-extension cycle and in idle gaps show that nothing leaks between neighbouring operations.

// File: rtl/smul_pkg.sv
package smul_pkg;
  // Bits that travel together at two registers per cell.
  typedef struct packed {
    logic x;    // multiplicand bit
    logic r;    // frame control: low on the bit-0 cycle
  } xr_t;
endpackage

// File: rtl/smul_fa.sv
module smul_fa (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  always_comb begin
    s  = a ^ b ^ ci;
    co = (a & b) | (a & ci) | (b & ci);
  end
endmodule

// File: rtl/smul_cell.sv
// One stage of the array. SUB selects the final, subtracting stage.
module smul_cell #(
  parameter bit SUB = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic x_i,
  input  logic r_i,
  input  logic y_i,
  input  logic ps_i,
  output logic ps_o
);
  logic dig_q, cy_q, ps_q;
  logic dig, pp, cin, add_a, sum, cout, res;

  always_comb begin
    dig = r_i ? dig_q : y_i;     // frame start: take a new Y digit
    pp  = dig & x_i;
    cin = r_i ? cy_q : 1'b0;     // frame start: clear the carry
  end

  generate
    if (SUB) begin : g_sub
      // S - P computed as NOT(NOT S + P)
      always_comb add_a = ~ps_i;
      always_comb res   = ~sum;
    end else begin : g_add
      always_comb add_a = ps_i;
      always_comb res   = sum;
    end
  endgenerate

  smul_fa u_fa (.a(add_a), .b(pp), .ci(cin), .s(sum), .co(cout));

  always_ff @(posedge clk) begin
    if (rst) begin
      dig_q <= 1'b0;
      cy_q  <= 1'b0;
      ps_q  <= 1'b0;
    end else begin
      dig_q <= dig;
      cy_q  <= cout;
      // bit 0 of the sum is dropped; holding here repeats the top bit
      if (r_i) ps_q <= res;
    end
  end

  assign ps_o = ps_q;
endmodule

// File: rtl/smul_ctrl.sv
module smul_ctrl
  import smul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic x_bit,
  input  logic y_bit,
  output xr_t  xr_feed,
  output logic y_feed,
  output logic frame_mark,
  output logic frame_last,
  output logic busy
);
  localparam int PW = $clog2(N + 1);
  localparam logic [PW-1:0] POS_LAST = PW'(N);

  logic          busy_q, x_prev_q, accept, last;
  logic [PW-1:0] pos_q;

  always_comb begin
    accept     = start & ~busy_q;
    last       = busy_q && (pos_q == POS_LAST);
    xr_feed.x  = last ? x_prev_q : x_bit;   // sign extension of X
    xr_feed.r  = busy_q;
    y_feed     = last ? 1'b0 : y_bit;
    frame_mark = accept | busy_q;
    frame_last = last;
    busy       = busy_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      pos_q    <= '0;
      x_prev_q <= 1'b0;
    end else begin
      x_prev_q <= x_bit;
      if (accept) begin
        busy_q <= 1'b1;
        pos_q  <= PW'(1);
      end else if (busy_q) begin
        if (last) begin
          busy_q <= 1'b0;
          pos_q  <= '0;
        end else begin
          pos_q <= pos_q + PW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/serial_tc_mult.sv
module serial_tc_mult
  import smul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic x_bit,
  input  logic y_bit,
  output logic out_bit,
  output logic out_valid
);
  localparam int LAT = 2 * N;

  xr_t          xr_c [0:N-1];
  logic [N-1:0] y_c;
  logic [N:0]   ps_c;
  logic         y_feed, frame_mark, frame_last, ctl_busy, x_feed;
  logic [LAT-1:0] mark_sr, last_sr;

  smul_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .x_bit(x_bit), .y_bit(y_bit),
    .xr_feed(xr_c[0]), .y_feed(y_feed), .frame_mark(frame_mark),
    .frame_last(frame_last), .busy(ctl_busy)
  );

  assign x_feed  = xr_c[0].x;
  assign ps_c[0] = 1'b0;
  assign y_c[0]  = y_feed;

  // Y moves one register per cell
  generate
    if (N > 1) begin : g_ydly
      always_ff @(posedge clk) begin
        if (rst) y_c[N-1:1] <= '0;
        else     y_c[N-1:1] <= y_c[N-2:0];
      end
    end
  endgenerate

  // X and control move two registers per cell
  generate
    for (genvar p = 0; p < N - 1; p++) begin : g_xdly
      xr_t mid_q, out_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          mid_q <= '0;
          out_q <= '0;
        end else begin
          mid_q <= xr_c[p];
          out_q <= mid_q;
        end
      end
      assign xr_c[p+1] = out_q;
    end
  endgenerate

  generate
    for (genvar p = 0; p < N; p++) begin : g_cell
      smul_cell #(.SUB(p == N - 1)) u_cell (
        .clk(clk), .rst(rst), .x_i(xr_c[p].x), .r_i(xr_c[p].r),
        .y_i(y_c[p]), .ps_i(ps_c[p]), .ps_o(ps_c[p+1])
      );
    end
  endgenerate

  // frame marks ride alongside to the array exit
  always_ff @(posedge clk) begin
    if (rst) begin
      mark_sr <= '0;
      last_sr <= '0;
    end else begin
      mark_sr <= {mark_sr[LAT-2:0], frame_mark};
      last_sr <= {last_sr[LAT-2:0], frame_last};
    end
  end

  assign out_bit   = ps_c[N];
  assign out_valid = mark_sr[LAT-1] & ~last_sr[LAT-1];
endmodule

// File: rtl/serial_tc_mult_chk.sv
module serial_tc_mult_chk #(
  parameter int N = 8
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic last,
  input logic x_feed,
  input logic out_valid
);
  localparam int CW = $clog2(N + 1) + 1;
  logic [CW-1:0] vrun_q, brun_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vrun_q <= '0;
      brun_q <= '0;
    end else begin
      vrun_q <= out_valid ? vrun_q + CW'(1) : '0;
      brun_q <= busy ? brun_q + CW'(1) : '0;
    end
  end

  // R7
  valid_run_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> vrun_q < CW'(N));

  // R4
  valid_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(out_valid) |-> $past(vrun_q) == CW'(N - 1));

  // R1
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R1
  busy_run_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> brun_q < CW'(N));

  // R5
  ghost_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !last) |=> busy);

  // R6
  sign_ext_chk: assert property (@(posedge clk) disable iff (rst)
    last |-> x_feed == $past(x_feed));
endmodule

bind serial_tc_mult serial_tc_mult_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(ctl_busy),
  .last(frame_last), .x_feed(x_feed), .out_valid(out_valid)
);

// File: tb/test_serial_tc_mult.sv
module test_serial_tc_mult;
  localparam int N = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst, start, x_bit, y_bit;
  logic out_bit, out_valid;

  serial_tc_mult #(.N(N)) i_serial_tc_mult (
    .clk(clk), .rst(rst), .start(start), .x_bit(x_bit), .y_bit(y_bit),
    .out_bit(out_bit), .out_valid(out_valid)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [N-1:0] exp_q[$];
  int           cyc_q[$];
  string        lbl_q[$];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // scoreboard monitor
  int           bidx = 0;
  int           first_cyc = 0;
  logic [N-1:0] acc = '0;
  always @(negedge clk) begin
    if (!rst && out_valid && !done) begin
      if (bidx == 0) first_cyc = cyc;
      acc[bidx] = out_bit;
      if (bidx == N - 1) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected result", longint'(acc), 0);
        end else begin
          logic [N-1:0] e;
          int           ec;
          string        l;
          e  = exp_q.pop_front();
          ec = cyc_q.pop_front();
          l  = lbl_q.pop_front();
          check(acc == e, l, longint'(acc), longint'(e));
          check(first_cyc == ec, "R2 latency", first_cyc, ec);
        end
        bidx = 0;
      end else begin
        bidx = bidx + 1;
      end
    end
  end

  // driver: one operation of N+1 cycles, then idle cycles with noise
  task automatic do_op(input logic [N-1:0] xa, input logic [N-1:0] ya,
                       input int gap, input bit ghost, input string lbl);
    logic [2*N-1:0] pr;
    pr = {{N{xa[N-1]}}, xa} * {{N{ya[N-1]}}, ya};
    for (int j = 0; j <= N; j++) begin
      @(negedge clk);
      if (j == 0) begin
        exp_q.push_back(pr[2*N-1:N]);
        cyc_q.push_back(cyc + 2 * N);
        lbl_q.push_back(lbl);
      end
      start = (j == 0) || (ghost && (j == 2 || j == N - 1));   // R5
      if (j < N) begin
        x_bit = xa[j];
        y_bit = ya[j];
      end else begin
        x_bit = 1'($urandom());                                 // R6
        y_bit = 1'($urandom());
      end
    end
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      start = 1'b0;
      x_bit = 1'($urandom());                                   // R8
      y_bit = 1'($urandom());
    end
  endtask

  localparam logic [N-1:0] MOST_NEG = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] MOST_POS = {1'b0, {(N-1){1'b1}}};
  localparam logic [N-1:0] ONE      = N'(1);
  localparam logic [N-1:0] ALL1     = '1;

  initial begin
    rst = 1'b1; start = 1'b0; x_bit = 1'b0; y_bit = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      x_bit = 1'($urandom());
      check(out_valid == 1'b0, "R7 reset", out_valid, 0);
    end
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7 idle after reset", out_valid, 0);

    // R1 framing, R3 corner values
    do_op('0, '0, 2, 1'b0, "R3 zero");
    do_op(ONE, ONE, 1, 1'b0, "R3 one");
    do_op(MOST_NEG, MOST_NEG, 3, 1'b0, "R3 neg*neg");
    do_op(MOST_NEG, MOST_POS, 0, 1'b0, "R3 neg*pos");
    do_op(MOST_POS, MOST_NEG, 0, 1'b0, "R3 pos*neg");
    do_op(MOST_POS, MOST_POS, 1, 1'b0, "R3 pos*pos");
    do_op(ALL1, ALL1, 0, 1'b0, "R3 -1*-1");
    do_op(ALL1, MOST_NEG, 2, 1'b0, "R3 -1*neg");
    do_op(MOST_NEG, ONE, 1, 1'b0, "R3 neg*1");

    // R4 back to back
    for (int i = 0; i < 12; i++)
      do_op(N'($urandom()), (i % 3 == 0) ? MOST_NEG : N'($urandom()), 0, 1'b0, "R4 back-to-back");

    // R5 starts inside a frame
    for (int i = 0; i < 6; i++)
      do_op(N'($urandom()), N'($urandom()), i % 2, 1'b1, "R5 ghost start");

    // R6/R8 noise on the extension cycle and in idle gaps
    for (int i = 0; i < 30; i++)
      do_op(N'($urandom()), N'($urandom()), int'($urandom() % 4), 1'b0, "R6/R8 random");

    @(negedge clk);
    start = 1'b0;
    repeat (4 * N + 4) @(negedge clk);
    check(exp_q.size() == 0, "R2 missing results", exp_q.size(), 0);
    check(out_valid == 1'b0, "R7 idle at end", out_valid, 0);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected < %0d cycles", WATCHDOG, WATCHDOG);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule